// File: doc/BRIEF.md
# Line Jitter Attenuator Elastic Buffer

This block cleans up the timing of one E1 or T1 bit stream. Bits arrive on a jittery line strobe and are stored in an elastic bit buffer. They are read out again on a smooth strobe. The smooth strobe comes from a divider running on the master clock, which itself runs at sixteen times the line rate. In steady state the divider counts 16 master cycles per output bit. When the buffer comes close to full, the divider shortens a period to 15 cycles so that the buffer drains. When the buffer comes close to empty, it stretches a period to 17 cycles so that the buffer refills. Each shortened or stretched period sets a sticky limit flag, which software clears with a strobe.

The buffer can be 32 bits deep for low latency or 128 bits deep for lines with large wander. It can sit in the receive lane, in the transmit lane, or in neither lane (bypass). A lane that does not pass through the buffer is copied to its output through a single register. Each lane is a valid-qualified bit stream with no ready signal. A line cannot be stalled, so there is no back-pressure: every input valid pulse is either accepted or, when the buffer is full, dropped. Every output valid pulse must be taken by the consumer in that same cycle. All inputs and outputs are in the master-clock domain, and the reset is synchronous and active low.

Top module: `jitter_smoother`

## Requirements
- R1: The buffer re-centres after reset or after any change of `cfg_deep`, `cfg_enable` or `cfg_tx_path`. Re-centring takes effect at the next clock edge and sets `fill_level` to half the selected depth (16 or 64). It also clears the limit flag, and both output valids stay 0 until the first read.
- R2: The buffered lane puts out half-depth zero bits first. After those it puts out the written bits in exactly the order they were written.
- R3: When one bit is written every 16 cycles, output valid pulses are spaced exactly 16 cycles apart and `limit_flag` stays 0.
- R4: If `fill_level` is at least depth minus 4 when a read period ends, the next period is 15 cycles long.
- R5: If `fill_level` is at most 4 when a read period ends, the next period is 17 cycles long.
- R6: Every 15-cycle or 17-cycle period sets `limit_flag` to 1. The flag stays at 1 until it is cleared.
- R7: While `trip_clear` is 1, `limit_flag` reads 0 in that same cycle. After that edge the flag stays 0 unless a new 15-cycle or 17-cycle period starts.
- R8: With `cfg_enable` = 0 (bypass), each lane output equals its input bit and valid delayed by one clock. In bypass, `limit_flag` is held at 0.
- R9: With `cfg_enable` = 1, `cfg_tx_path` = 0 places the buffer in the receive lane and `cfg_tx_path` = 1 places it in the transmit lane. The other lane is passed through with one register of delay.
- R10: `cfg_deep` = 1 selects a depth of 128 bits and `cfg_deep` = 0 selects a depth of 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 16x line rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_deep | input | 1 | 1 = 128-bit depth, 0 = 32-bit depth |
| cfg_enable | input | 1 | 1 = buffer in use, 0 = bypass both lanes |
| cfg_tx_path | input | 1 | 1 = buffer in transmit lane, 0 = receive lane |
| rx_in_bit | input | 1 | Receive lane data bit |
| rx_in_valid | input | 1 | Receive lane one-cycle line strobe |
| tx_in_bit | input | 1 | Transmit lane data bit |
| tx_in_valid | input | 1 | Transmit lane one-cycle line strobe |
| trip_clear | input | 1 | Clears the limit flag, effective the same cycle |
| rx_out_bit | output | 1 | Receive lane output bit |
| rx_out_valid | output | 1 | Receive lane output strobe |
| tx_out_bit | output | 1 | Transmit lane output bit |
| tx_out_valid | output | 1 | Transmit lane output strobe |
| limit_flag | output | 1 | Sticky limit-trip status |
| fill_level | output | 8 | Current buffer fill in bits |

## Verification
The bench drives writes slightly faster than the nominal rate until the fill reaches the upper margin, and slightly slower until it reaches the lower margin. A design with swapped thresholds would show the wrong period length, and a missing margin check would let the buffer overrun and break the scoreboard order. The bench compares the half-depth run of leading zeros in both depths and checks the re-centred fill after a depth change. A design that keeps a stale depth would shift every bit in the output stream. The bench also checks that the clear strobe masks the flag in its own cycle, that the flag persists once the fill has moved off the margin, and that bypass echoes each lane one cycle late with the flag forced low.

// File: rtl/jas_pkg.sv
package jas_pkg;
  typedef struct packed {
    logic deep;
    logic enable;
    logic tx_path;
  } jas_cfg_t;

  localparam int LANES = 2;
  localparam int LANE_RX = 0;
  localparam int LANE_TX = 1;
endpackage

// File: rtl/jas_bitbuf.sv
module jas_bitbuf #(
  parameter int DS = 32,
  parameter int DD = 128,
  parameter int AW = $clog2(DD),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          deep,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_en,
  output logic          rd_bit,
  output logic          rd_valid,
  output logic [PW-1:0] fill
);
  logic [DD-1:0] mem;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] depth, half, pmask;
  logic [AW-1:0] imask;
  logic          full, empty, do_wr, do_rd;

  always_comb begin
    depth = deep ? PW'(DD) : PW'(DS);
    half  = depth >> 1;
    pmask = deep ? {PW{1'b1}} : PW'(2 * DS - 1);
    imask = deep ? AW'(DD - 1) : AW'(DS - 1);
    fill  = (wr_ptr - rd_ptr) & pmask;
    full  = (fill == depth);
    empty = (fill == '0);
    do_wr = wr_en && !full;
    do_rd = rd_en && !empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      mem      <= '0;
      wr_ptr   <= half;
      rd_ptr   <= '0;
      rd_bit   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (do_wr) begin
        mem[wr_ptr[AW-1:0] & imask] <= wr_bit;
        wr_ptr <= (wr_ptr + PW'(1)) & pmask;
      end
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_bit <= empty ? 1'b0 : mem[rd_ptr[AW-1:0] & imask];
      end
      if (do_rd) begin
        rd_ptr <= (rd_ptr + PW'(1)) & pmask;
      end
    end
  end

  a_r2_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= depth);

  a_r1_recentre: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (fill == ($past(depth) >> 1)));
endmodule

// File: rtl/jas_rdclk.sv
module jas_rdclk #(
  parameter int DS      = 32,
  parameter int DD      = 128,
  parameter int MARGIN  = 4,
  parameter int DIV_NOM = 16,
  parameter int AW      = $clog2(DD),
  localparam int PW     = AW + 1,
  localparam int CW     = $clog2(DIV_NOM + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic          deep,
  input  logic [PW-1:0] fill,
  output logic          tick,
  output logic          trip
);
  logic [CW-1:0] cnt, len, next_len;
  logic [PW-1:0] depth;

  always_comb begin
    depth = deep ? PW'(DD) : PW'(DS);
    if (fill >= depth - PW'(MARGIN))
      next_len = CW'(DIV_NOM - 1);
    else if (fill <= PW'(MARGIN))
      next_len = CW'(DIV_NOM + 1);
    else
      next_len = CW'(DIV_NOM);
    tick = run && (cnt == len - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      cnt  <= '0;
      len  <= CW'(DIV_NOM);
      trip <= 1'b0;
    end else begin
      trip <= 1'b0;
      if (tick) begin
        cnt  <= '0;
        len  <= next_len;
        trip <= (next_len != CW'(DIV_NOM));
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r6_trip_marks_odd_period: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> (len != CW'(DIV_NOM)));
endmodule

// File: rtl/jas_trip_flag.sv
module jas_trip_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n || hold)
      flag_q <= 1'b0;
    else if (set)
      flag_q <= 1'b1;
    else if (clr)
      flag_q <= 1'b0;
  end

  assign flag = flag_q & ~clr;

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr && !hold) |=> flag_q);

  a_r7_clear_next: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/jitter_smoother.sv
module jitter_smoother #(
  parameter int DS      = 32,
  parameter int DD      = 128,
  parameter int MARGIN  = 4,
  parameter int DIV_NOM = 16,
  localparam int AW     = $clog2(DD),
  localparam int PW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_deep,
  input  logic          cfg_enable,
  input  logic          cfg_tx_path,
  input  logic          rx_in_bit,
  input  logic          rx_in_valid,
  input  logic          tx_in_bit,
  input  logic          tx_in_valid,
  input  logic          trip_clear,
  output logic          rx_out_bit,
  output logic          rx_out_valid,
  output logic          tx_out_bit,
  output logic          tx_out_valid,
  output logic          limit_flag,
  output logic [PW-1:0] fill_level
);
  import jas_pkg::*;

  jas_cfg_t          cfg, cfg_q;
  logic              restart;
  logic [LANES-1:0]  in_b, in_v, pass_b, pass_v;
  logic              buf_wr_en, buf_wr_bit, buf_bit, buf_valid;
  logic              rd_tick, trip_pulse;

  assign cfg     = '{deep: cfg_deep, enable: cfg_enable, tx_path: cfg_tx_path};
  assign restart = rst_n && (cfg != cfg_q);

  always_ff @(posedge clk) begin
    cfg_q <= cfg;
  end

  assign in_b = {tx_in_bit, rx_in_bit};
  assign in_v = {tx_in_valid, rx_in_valid};

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_pass
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pass_b[g] <= 1'b0;
          pass_v[g] <= 1'b0;
        end else begin
          pass_b[g] <= in_b[g];
          pass_v[g] <= in_v[g];
        end
      end
    end
  endgenerate

  assign buf_wr_bit = cfg_tx_path ? tx_in_bit : rx_in_bit;
  assign buf_wr_en  = cfg_enable && (cfg_tx_path ? tx_in_valid : rx_in_valid);

  jas_bitbuf #(.DS(DS), .DD(DD), .AW(AW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .deep     (cfg_deep),
    .wr_en    (buf_wr_en),
    .wr_bit   (buf_wr_bit),
    .rd_en    (rd_tick),
    .rd_bit   (buf_bit),
    .rd_valid (buf_valid),
    .fill     (fill_level)
  );

  jas_rdclk #(.DS(DS), .DD(DD), .MARGIN(MARGIN), .DIV_NOM(DIV_NOM), .AW(AW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (cfg_enable),
    .deep    (cfg_deep),
    .fill    (fill_level),
    .tick    (rd_tick),
    .trip    (trip_pulse)
  );

  jas_trip_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (!cfg_enable || restart),
    .set   (trip_pulse),
    .clr   (trip_clear),
    .flag  (limit_flag)
  );

  always_comb begin
    rx_out_bit   = pass_b[LANE_RX];
    rx_out_valid = pass_v[LANE_RX];
    tx_out_bit   = pass_b[LANE_TX];
    tx_out_valid = pass_v[LANE_TX];
    if (cfg_enable && !cfg_tx_path) begin
      rx_out_bit   = buf_bit;
      rx_out_valid = buf_valid;
    end
    if (cfg_enable && cfg_tx_path) begin
      tx_out_bit   = buf_bit;
      tx_out_valid = buf_valid;
    end
  end

  // spacing of buffered output strobes, measured independently of the divider
  logic [5:0] chk_gap;
  logic       chk_seen;
  always_ff @(posedge clk) begin
    if (!rst_n || restart || !cfg_enable) begin
      chk_gap  <= '0;
      chk_seen <= 1'b0;
    end else if (buf_valid) begin
      chk_gap  <= '0;
      chk_seen <= 1'b1;
    end else if (chk_gap != 6'h3f) begin
      chk_gap <= chk_gap + 6'd1;
    end
  end

  a_r4_r5_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && chk_seen && cfg_enable && !restart) |->
      (chk_gap >= 6'(DIV_NOM - 2) && chk_gap <= 6'(DIV_NOM)));

  a_r8_bypass_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !u_flag.flag_q);
endmodule

// File: tb/jitter_smoother_tb.sv
module jitter_smoother_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DS = 32;
  localparam int DD = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_deep = 1'b0, cfg_enable = 1'b1, cfg_tx_path = 1'b0;
  logic rx_in_bit = 1'b0, rx_in_valid = 1'b0;
  logic tx_in_bit = 1'b0, tx_in_valid = 1'b0;
  logic trip_clear = 1'b0;
  logic rx_out_bit, rx_out_valid, tx_out_bit, tx_out_valid, limit_flag;
  logic [7:0] fill_level;

  always #(CLK_PERIOD / 2) clk = ~clk;

  jitter_smoother #(.DS(DS), .DD(DD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_deep(cfg_deep), .cfg_enable(cfg_enable),
    .cfg_tx_path(cfg_tx_path), .rx_in_bit(rx_in_bit), .rx_in_valid(rx_in_valid),
    .tx_in_bit(tx_in_bit), .tx_in_valid(tx_in_valid), .trip_clear(trip_clear),
    .rx_out_bit(rx_out_bit), .rx_out_valid(rx_out_valid), .tx_out_bit(tx_out_bit),
    .tx_out_valid(tx_out_valid), .limit_flag(limit_flag), .fill_level(fill_level)
  );

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  bit mon_on = 1'b0;
  bit mon_tx = 1'b0;
  int gap_cnt = 0;
  bit gap_seen = 1'b0;
  int n15 = 0, n16 = 0, n17 = 0, nother = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n || !mon_on) begin
      gap_cnt  = 0;
      gap_seen = 1'b0;
    end else begin
      bit v, b, e;
      v = mon_tx ? tx_out_valid : rx_out_valid;
      b = mon_tx ? tx_out_bit : rx_out_bit;
      gap_cnt++;
      if (v) begin
        if (gap_seen) begin
          if (gap_cnt == 15) n15++;
          else if (gap_cnt == 16) n16++;
          else if (gap_cnt == 17) n17++;
          else nother++;
        end
        gap_seen = 1'b1;
        gap_cnt  = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected output bit", int'(b), -1);
        end else begin
          e = exp_q.pop_front();
          check(b == e, "R2 output order", int'(b), int'(e));
        end
      end
    end
  end

  task automatic clear_stats();
    n15 = 0; n16 = 0; n17 = 0; nother = 0;
  endtask

  task automatic do_reset(input bit deep, input bit en, input bit txp);
    @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0;
    cfg_deep = deep; cfg_enable = en; cfg_tx_path = txp;
    rx_in_valid = 0; tx_in_valid = 0; rx_in_bit = 0; tx_in_bit = 0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    for (int i = 0; i < (deep ? DD : DS) / 2; i++) exp_q.push_back(1'b0);
    clear_stats();
    rst_n = 1'b1;
    mon_tx = txp;
  endtask

  task automatic write_bit(input bit b, input int spacing);
    if (cfg_tx_path) begin tx_in_bit = b; tx_in_valid = 1'b1; end
    else begin rx_in_bit = b; rx_in_valid = 1'b1; end
    exp_q.push_back(b);
    @(negedge clk);
    rx_in_valid = 1'b0; tx_in_valid = 1'b0;
    repeat (spacing - 1) @(negedge clk);
  endtask

  task automatic write_run(input int n, input int spacing, input int seed);
    for (int i = 0; i < n; i++) write_bit(bit'(((i * 5 + seed) ^ (i >> 2)) & 1), spacing);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state, R10 shallow depth
    do_reset(1'b0, 1'b1, 1'b0);
    #1;
    check(fill_level == 8'd16, "R1 reset fill (R10 depth 32)", fill_level, 16);
    check(limit_flag == 1'b0, "R1 reset flag", limit_flag, 0);
    check(rx_out_valid == 1'b0 && tx_out_valid == 1'b0, "R1 no output before read",
          rx_out_valid, 0);
    // depth change re-centres
    @(negedge clk);
    cfg_deep = 1'b1;
    @(negedge clk); #1;
    check(fill_level == 8'd64, "R1 re-centre on depth change (R10 depth 128)", fill_level, 64);

    // R3 balanced, shallow; R2 via scoreboard
    do_reset(1'b0, 1'b1, 1'b0);
    mon_on = 1'b1;
    write_run(120, 16, 1);
    check(nother == 0 && n15 == 0 && n17 == 0, "R3 periods all 16", n15 + n17 + nother, 0);
    check(n16 > 50, "R3 periods seen", n16, 100);
    check(limit_flag == 1'b0, "R3 flag stays low", limit_flag, 0);

    // R10 deep, balanced: 64 leading zeros then data (R2)
    do_reset(1'b1, 1'b1, 1'b0);
    mon_on = 1'b1;
    write_run(200, 16, 3);
    check(n15 == 0 && n17 == 0, "R10 deep no trips", n15 + n17, 0);
    check(limit_flag == 1'b0, "R10 deep flag low", limit_flag, 0);

    // R4 high fill: write every 15 cycles
    do_reset(1'b0, 1'b1, 1'b0);
    mon_on = 1'b1;
    write_run(400, 15, 2);
    check(n15 > 0, "R4 shortened period seen", n15, 1);
    check(n17 == 0, "R4 no stretched period", n17, 0);
    check(limit_flag == 1'b1, "R6 flag set by short period", limit_flag, 1);
    // writes stop; fill moves off the margin, flag persists
    repeat (100) @(negedge clk);
    #1;
    check(limit_flag == 1'b1, "R6 flag sticky", limit_flag, 1);
    @(negedge clk);
    trip_clear = 1'b1;
    #1;
    check(limit_flag == 1'b0, "R7 clear same cycle", limit_flag, 0);
    @(negedge clk);
    trip_clear = 1'b0;
    #1;
    check(limit_flag == 1'b0, "R7 flag stays cleared", limit_flag, 0);
    repeat (40) @(negedge clk);
    #1;
    check(limit_flag == 1'b0, "R7 no new trip", limit_flag, 0);

    // R5 low fill: write every 17 cycles
    do_reset(1'b0, 1'b1, 1'b0);
    mon_on = 1'b1;
    write_run(400, 17, 4);
    check(n17 > 0, "R5 stretched period seen", n17, 1);
    check(n15 == 0, "R5 no shortened period", n15, 0);
    check(limit_flag == 1'b1, "R6 flag set by long period", limit_flag, 1);

    // R8 bypass: flag held low, one-register echo on both lanes
    mon_on = 1'b0;
    cfg_enable = 1'b0;
    @(negedge clk); #1;
    check(limit_flag == 1'b0, "R8 flag held clear in bypass", limit_flag, 0);
    begin
      bit pb_r = 0, pv_r = 0, pb_t = 0, pv_t = 0;
      for (int i = 0; i < 12; i++) begin
        check(rx_out_bit == pb_r && rx_out_valid == pv_r, "R8 rx echo",
              {rx_out_valid, rx_out_bit}, {pv_r, pb_r});
        check(tx_out_bit == pb_t && tx_out_valid == pv_t, "R8 tx echo",
              {tx_out_valid, tx_out_bit}, {pv_t, pb_t});
        pb_r = bit'((i * 3) & 1); pv_r = bit'((i % 3) != 0);
        pb_t = bit'(i & 1);       pv_t = bit'((i % 2) == 0);
        rx_in_bit = pb_r; rx_in_valid = pv_r;
        tx_in_bit = pb_t; tx_in_valid = pv_t;
        @(negedge clk); #1;
      end
      rx_in_valid = 0; tx_in_valid = 0;
    end

    // R9 transmit-lane placement, receive lane passes through
    do_reset(1'b0, 1'b1, 1'b1);
    mon_on = 1'b1;
    write_run(60, 16, 5);
    begin
      bit pb = 0, pv = 0;
      for (int i = 0; i < 8; i++) begin
        rx_in_bit = bit'((i >> 1) & 1); rx_in_valid = bit'(i & 1);
        pb = rx_in_bit; pv = rx_in_valid;
        @(negedge clk); #1;
        check(rx_out_bit == pb && rx_out_valid == pv, "R9 rx passes one cycle late",
              {rx_out_valid, rx_out_bit}, {pv, pb});
      end
      rx_in_valid = 0;
    end
    write_run(40, 16, 6);
    check(n16 > 30 && nother == 0, "R9 tx lane buffered periods", n16, 30);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule